// File: doc/BRIEF.md
# Configurable PAL Output Macrocell

This block is one output cell of a small sum-of-products logic device. It receives eight product terms from the AND array and ORs them into a single sum. It applies a per-cell polarity to that sum. The result then goes to the output pad either straight through as combinational logic or through a D register clocked by the device clock. The cell also returns a feedback bit to the array.

Two global configuration bits, shared by every cell of the device, and one local bit per cell pick the cell's personality. The cell can be a plain combinational output, a combinational output with a product-term enable, an input-only pin, or a registered output. In the registered personality the output enable comes from the shared enable pin.

The register has a synchronous preload path for test. It is cleared on power-up by an active-low reset that asserts asynchronously and releases on the second rising clock edge. The tri-state pad is represented by a data, an enable and a returned pad-level signal, so that a pad cell can sit outside.

Top module: `pal_macrocell`

## Requirements
- R1: With global mode 2'b00 and local bit 0, the cell is a plain combinational output. pad_oe_o is 1, and the sum is the OR of all eight product terms pterm_i[7:0].
- R2: pol_i = 1 makes the driven value equal to the sum (active-high). pol_i = 0 makes it the inverted sum (active-low). This holds for both the combinational and the registered path.
- R3: With global mode 2'b01 and local bit 0, or global bit 1 set and local bit 0, the cell is combinational with a term-controlled enable. pad_oe_o equals pterm_i[7], and only pterm_i[6:0] enter the sum.
- R4: With global mode 2'b00 or 2'b01 and local bit 1, the pin is input-only. pad_oe_o is 0 at all times.
- R5: With global bit 1 set and local bit 1, the cell is registered. pad_o shows the register, which loads the polarity-applied sum of all eight terms at each rising clock edge. pad_oe_o equals the inverse of the active-low enable pin oe_n_i. fb_o is the inverse of the register.
- R6: In every non-registered configuration, fb_o equals the level on the pad, pad_i.
- R7: When pre_en_i is 1 at a rising edge with the reset released, the register loads pre_val_i instead of the sum. This works in every configuration.
- R8: While rst_ni is 0 the register is 0, and preload has no effect. After rst_ni rises, the register stays 0 through the second rising edge and first loads on the third.
- R9: In non-registered configurations, the register holds its value across clock edges unless it is preloaded.
- R10: Global mode 2'b11 behaves exactly like global mode 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared device clock |
| rst_ni | input | 1 | Active-low power-up reset, asynchronous assert |
| oe_n_i | input | 1 | Shared active-low output-enable pin |
| pterm_i | input | NUM_PT | Product terms from the AND array |
| glb_cfg_i | input | 2 | Global configuration bits shared by all cells |
| loc_cfg_i | input | 1 | Per-cell configuration bit |
| pol_i | input | 1 | Output polarity, 1 = active-high |
| pre_en_i | input | 1 | Register preload strobe |
| pre_val_i | input | 1 | Register preload value |
| pad_i | input | 1 | Level seen on the pad |
| pad_o | output | 1 | Data driven toward the pad |
| pad_oe_o | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback bit to the AND array |

## Verification
A wrong register value shows on pad_o and, inverted, on fb_o in the registered personality on the first edge after the fault. In other personalities it stays hidden until the cell is switched to a registered configuration, so the bench preloads in combinational modes and then switches the configuration. A wrong decode of the configuration bits shows at once as a wrong enable, a wrong feedback source, or a sum that does or does not respond to the eighth term. The reset-release delay shows as a register that loads one edge too early or too late.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;

  typedef enum logic [1:0] {
    GM_SIMPLE  = 2'b00,
    GM_CPLX    = 2'b01,
    GM_REG     = 2'b10,
    GM_REG_ALT = 2'b11
  } glb_mode_e;

  typedef enum logic [1:0] {
    OE_ALWAYS,
    OE_NEVER,
    OE_PIN,
    OE_TERM
  } oe_src_e;

  typedef enum logic {
    FB_PAD,
    FB_REG_N
  } fb_src_e;

  typedef struct packed {
    logic    from_reg;
    logic    all_terms;
    oe_src_e oe_src;
    fb_src_e fb_src;
  } mc_sel_t;

endpackage

// File: rtl/pal_mc_decode.sv
module pal_mc_decode
  import pal_mc_pkg::*;
(
  input  glb_mode_e glb_i,
  input  logic      loc_i,
  output mc_sel_t   sel_o
);

  always_comb begin
    sel_o.from_reg  = 1'b0;
    sel_o.all_terms = 1'b1;
    sel_o.oe_src    = OE_ALWAYS;
    sel_o.fb_src    = FB_PAD;
    unique case (glb_i)
      GM_SIMPLE: begin
        sel_o.oe_src = loc_i ? OE_NEVER : OE_ALWAYS;
      end
      GM_CPLX: begin
        sel_o.oe_src    = loc_i ? OE_NEVER : OE_TERM;
        sel_o.all_terms = loc_i;
      end
      GM_REG, GM_REG_ALT: begin
        if (loc_i) begin
          sel_o.from_reg = 1'b1;
          sel_o.oe_src   = OE_PIN;
          sel_o.fb_src   = FB_REG_N;
        end else begin
          sel_o.oe_src    = OE_TERM;
          sel_o.all_terms = 1'b0;
        end
      end
      default: begin
        sel_o.oe_src = OE_NEVER;
      end
    endcase
  end

endmodule

// File: rtl/pal_mc_sum.sv
module pal_mc_sum #(
  parameter int NUM_PT = 8
) (
  input  logic [NUM_PT-1:0] pterm_i,
  input  logic              all_terms_i,
  input  logic              pol_i,
  output logic              val_o
);

  localparam int LAST = NUM_PT - 1;

  logic [NUM_PT-1:0] used;
  logic              sum;

  for (genvar g = 0; g < NUM_PT; g++) begin : g_term
    if (g == LAST) begin : g_last
      assign used[g] = pterm_i[g] & all_terms_i;
    end else begin : g_data
      assign used[g] = pterm_i[g];
    end
  end

  assign sum   = |used;
  assign val_o = pol_i ? sum : ~sum;

endmodule

// File: rtl/pal_mc_rst_sync.sv
module pal_mc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/pal_mc_reg.sv
module pal_mc_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pre_en_i,
  input  logic pre_val_i,
  input  logic cap_en_i,
  input  logic d_i,
  output logic q_o
);

  logic q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (pre_en_i)      q_nxt = pre_val_i;
    else if (cap_en_i) q_nxt = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_nxt;
  end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_mc_pkg::*;
#(
  parameter int NUM_PT     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              oe_n_i,
  input  logic [NUM_PT-1:0] pterm_i,
  input  logic [1:0]        glb_cfg_i,
  input  logic              loc_cfg_i,
  input  logic              pol_i,
  input  logic              pre_en_i,
  input  logic              pre_val_i,
  input  logic              pad_i,
  output logic              pad_o,
  output logic              pad_oe_o,
  output logic              fb_o
);

  localparam int LAST = NUM_PT - 1;

  mc_sel_t sel;
  logic    comb_val;
  logic    rst_sync_n;
  logic    reg_q;

  pal_mc_decode u_decode (
    .glb_i (glb_mode_e'(glb_cfg_i)),
    .loc_i (loc_cfg_i),
    .sel_o (sel)
  );

  pal_mc_sum #(.NUM_PT(NUM_PT)) u_sum (
    .pterm_i     (pterm_i),
    .all_terms_i (sel.all_terms),
    .pol_i       (pol_i),
    .val_o       (comb_val)
  );

  pal_mc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  pal_mc_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .pre_en_i  (pre_en_i),
    .pre_val_i (pre_val_i),
    .cap_en_i  (sel.from_reg),
    .d_i       (comb_val),
    .q_o       (reg_q)
  );

  // output data select
  always_comb begin
    pad_o = sel.from_reg ? reg_q : comb_val;
  end

  // enable source select
  always_comb begin
    unique case (sel.oe_src)
      OE_ALWAYS: pad_oe_o = 1'b1;
      OE_NEVER:  pad_oe_o = 1'b0;
      OE_PIN:    pad_oe_o = ~oe_n_i;
      OE_TERM:   pad_oe_o = pterm_i[LAST];
      default:   pad_oe_o = 1'b0;
    endcase
  end

  // feedback source select
  always_comb begin
    unique case (sel.fb_src)
      FB_REG_N: fb_o = ~reg_q;
      default:  fb_o = pad_i;
    endcase
  end

endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk #(
  parameter int NUM_PT     = 8,
  parameter int RST_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              oe_n_i,
  input logic [NUM_PT-1:0] pterm_i,
  input logic [1:0]        glb_cfg_i,
  input logic              loc_cfg_i,
  input logic              pre_en_i,
  input logic              pre_val_i,
  input logic              pad_i,
  input logic              pad_o,
  input logic              pad_oe_o,
  input logic              fb_o
);

  localparam int CW  = $clog2(RST_STAGES + 2);
  localparam int TOP = RST_STAGES + 1;

  logic [CW-1:0] since_rst;
  logic          is_reg, is_inp, is_term;

  assign is_reg  = glb_cfg_i[1] & loc_cfg_i;
  assign is_inp  = ~glb_cfg_i[1] & loc_cfg_i;
  assign is_term = ~loc_cfg_i & (glb_cfg_i != 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       since_rst <= '0;
    else if (since_rst != CW'(TOP))    since_rst <= since_rst + 1'b1;
  end

  assert_term_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_term |-> (pad_oe_o == pterm_i[NUM_PT-1]));

  assert_input_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_inp |-> !pad_oe_o);

  assert_reg_fb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_reg |-> (fb_o == !pad_o));

  assert_reg_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_reg |-> (pad_oe_o == !oe_n_i));

  assert_pad_fb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_reg |-> (fb_o == pad_i));

  assert_preload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == CW'(TOP) && $past(pre_en_i) && is_reg) |-> (pad_o == $past(pre_val_i)));

  assert_reset_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < CW'(TOP) && is_reg) |-> !pad_o);

endmodule

bind pal_macrocell pal_macrocell_chk #(.NUM_PT(NUM_PT), .RST_STAGES(RST_STAGES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .oe_n_i    (oe_n_i),
  .pterm_i   (pterm_i),
  .glb_cfg_i (glb_cfg_i),
  .loc_cfg_i (loc_cfg_i),
  .pre_en_i  (pre_en_i),
  .pre_val_i (pre_val_i),
  .pad_i     (pad_i),
  .pad_o     (pad_o),
  .pad_oe_o  (pad_oe_o),
  .fb_o      (fb_o)
);

// File: tb/pal_macrocell_test.sv
`timescale 1ns/1ps
module pal_macrocell_test;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       oe_n;
  logic [7:0] pterm;
  logic [1:0] glb;
  logic       loc, pol, pre_en, pre_val, ext_val;
  logic       pad_i, pad_o, pad_oe, fb;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic       m_q;
  logic [1:0] m_sync;

  always #5 clk = ~clk;

  assign pad_i = pad_oe ? pad_o : ext_val;

  pal_macrocell uut (
    .clk_i (clk), .rst_ni (rst_ni), .oe_n_i (oe_n), .pterm_i (pterm),
    .glb_cfg_i (glb), .loc_cfg_i (loc), .pol_i (pol),
    .pre_en_i (pre_en), .pre_val_i (pre_val), .pad_i (pad_i),
    .pad_o (pad_o), .pad_oe_o (pad_oe), .fb_o (fb)
  );

  function automatic bit f_is_reg(input logic [1:0] g, input logic l);
    return g[1] & l;
  endfunction

  function automatic bit f_is_inp(input logic [1:0] g, input logic l);
    return !g[1] & l;
  endfunction

  function automatic bit f_val(input logic [7:0] p, input bit all8, input logic pl);
    bit s;
    s = all8 ? (|p) : (|p[6:0]);
    return pl ? s : !s;
  endfunction

  task automatic chk(input logic got, input logic exp, input string req);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b (glb=%b loc=%b pt=%b pol=%b)",
               req, got, exp, glb, loc, pterm, pol);
    end
  endtask

  // reference update at a rising edge
  task automatic model_edge();
    if (!rst_ni) begin
      m_q = 1'b0; m_sync = 2'b00;
    end else begin
      if (m_sync[1]) begin
        if (pre_en) m_q = pre_val;
        else if (f_is_reg(glb, loc)) m_q = f_val(pterm, 1'b1, pol);
      end
      m_sync = {m_sync[0], 1'b1};
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic check_all();
    bit r, inp, trm, eoe, epad;
    #1;
    if (!rst_ni) begin m_q = 1'b0; m_sync = 2'b00; end
    r   = f_is_reg(glb, loc);
    inp = f_is_inp(glb, loc);
    trm = !loc && (glb != 2'b00);
    if (r) begin
      chk(pad_o, m_q, "R5 reg data");
      chk(pad_oe, !oe_n, "R5 pin enable");
      chk(fb, !m_q, "R5 inverted feedback");
    end else begin
      epad = f_val(pterm, !trm, pol);
      eoe  = inp ? 1'b0 : (trm ? pterm[7] : 1'b1);
      if (inp)      chk(pad_oe, 1'b0, "R4 input-only");
      else if (trm) chk(pad_oe, eoe, "R3 term enable");
      else          chk(pad_oe, 1'b1, "R1 always enabled");
      if (!inp) chk(pad_o, epad, trm ? "R3 R2 seven-term sum" : "R1 R2 eight-term sum");
      chk(fb, eoe ? epad : ext_val, "R6 pad feedback");
    end
  endtask

  task automatic drive(input logic [1:0] g, input logic l, input logic pl,
                       input logic [7:0] p, input logic pe, input logic pv);
    glb = g; loc = l; pol = pl; pterm = p; pre_en = pe; pre_val = pv;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_ni = 1'b0; oe_n = 1'b0; ext_val = 1'b0;
    m_q = 1'b0; m_sync = 2'b00;
    drive(2'b10, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1);
    @(negedge clk);
    check_all();                               // R8 reset state
    cycle(); cycle();
    check_all();
    chk(pad_o, 1'b0, "R8 preload ignored in reset");

    // release: loads first at third edge
    rst_ni = 1'b1;
    drive(2'b10, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0);
    cycle(); check_all(); chk(pad_o, 1'b0, "R8 edge 1 after release");
    cycle(); check_all(); chk(pad_o, 1'b0, "R8 edge 2 after release");
    cycle(); check_all(); chk(pad_o, 1'b1, "R8 edge 3 loads");

    // R2 registered polarity active-low
    drive(2'b10, 1'b1, 1'b0, 8'h80, 1'b0, 1'b0);
    cycle(); check_all(); chk(pad_o, 1'b0, "R2 registered active-low");

    // R10 mode 11 same as registered
    drive(2'b11, 1'b1, 1'b1, 8'h80, 1'b0, 1'b0);
    cycle(); check_all(); chk(pad_o, 1'b1, "R10 mode 11 registers");
    chk(fb, 1'b0, "R10 mode 11 feedback");

    // R7 preload beats capture
    drive(2'b10, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b0);
    cycle(); check_all(); chk(pad_o, 1'b0, "R7 preload over sum");

    // R9 hold in combinational mode, R7 preload in combinational mode
    drive(2'b00, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
    cycle(); check_all();
    drive(2'b01, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    cycle(); check_all(); cycle(); check_all();
    drive(2'b10, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
    check_all(); chk(pad_o, 1'b1, "R9 R7 held preload value");

    // R3 eighth term does not enter the sum
    drive(2'b01, 1'b0, 1'b1, 8'h80, 1'b0, 1'b0);
    check_all(); chk(pad_o, 1'b0, "R3 term 7 excluded"); chk(pad_oe, 1'b1, "R3 term 7 enables");

    // R8 asynchronous clear mid-run
    drive(2'b10, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0);
    cycle(); cycle(); cycle(); check_all();
    rst_ni = 1'b0;
    check_all(); chk(pad_o, 1'b0, "R8 asynchronous clear");
    cycle(); rst_ni = 1'b1; check_all();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] p;
      for (int b = 0; b < 8; b++) p[b] = ($urandom % 6) == 0;
      drive(2'($urandom), 1'($urandom), 1'($urandom), p,
            ($urandom % 8) == 0, 1'($urandom));
      oe_n    = 1'($urandom);
      ext_val = 1'($urandom);
      rst_ni  = ($urandom % 200) != 0;
      check_all();
      cycle();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule